// File: doc/BRIEF.md
# Multi-core interrupt pending router

This block collects a bank of level-sensitive interrupt inputs and steers each one to a single core and to one of several output lines on that core. The target core of every interrupt and the output line of every group of 32 interrupts arrive already decoded on route inputs. The block tracks the raw input level and a per-interrupt enable mask. For each core it keeps a status word per group and a pending set per line. An output line is high while its pending set holds at least one interrupt.

Updates to the status and pending state go through a request queue. Each interrupt carries an up request and a down request. A priority scan serves the lowest numbered request once per clock. Input edges, enable-word writes and status-word clears only post requests, so no change is lost while a walk over several bits is running. A 32-bit register port gives access to the enable words and to the status words of the core named by the requester ID.

Top module: `irq_steer_router`

## Requirements
- R1: After reset the enable words and all status words read 0, every output line is low and `busy` is low.
- R2: The port decodes a 16-bit byte offset. Enable word w is at 0x0100 + 4*w and status word w is at 0x0200 + 4*w. Any other offset reads 0 and ignores writes.
- R3: Writing an enable word stores it, and the next read returns the written value.
- R4: A rising input on a disabled interrupt changes no status bit and no output line.
- R5: A rising input on an enabled interrupt i sets bit i%32 of status word i/32 of core route_core[i], and adds i to the pending set of line route_line[i/32] on that core. That line goes high two clocks after the input edge when no other request is queued.
- R6: An output line is the OR of its pending set. It stays high while any interrupt in the set remains and goes low when the last one is removed.
- R7: A falling input clears the interrupt's status bit and removes it from its pending set, whether the interrupt is enabled or not.
- R8: When an enable write turns a bit on and the raw level is high, that interrupt is raised again. When a write turns a bit off and the raw level is high, that interrupt is lowered. Queued requests are served one per clock, lowest interrupt number first.
- R9: Writing a status word clears every bit written as 1 at once. Each of those bits that was set is also removed from its pending set, so the line drops when the set becomes empty.
- R10: Status reads and writes act on the core given by `reg_req_id`, not on a core taken from the offset.
- R11: `busy` is high exactly while at least one request is queued. An input edge that arrives during a walk is queued and served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Interrupt levels |
| route_core | input | N_IRQ*CORE_W | Decoded target core, one field per interrupt |
| route_line | input | N_WORD*LINE_W | Decoded output line, one field per group of 32 |
| reg_ofs | input | 16 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_req_id | input | CORE_W | Requester core for status accesses |
| reg_rdata | output | 32 | Read data for the current offset |
| line_out | output | N_CORE*N_LINE | Output lines, index core*N_LINE+line |
| busy | output | 1 | Requests queued |

## Verification
The assertions check on every cycle that the scan serves a queued request and the lowest one, and that an idle queue serves nothing. They also check that a falling edge always queues a down request, that a rising edge on a disabled interrupt never queues an up request, and that a line rises or falls only right after an up or down service. Replay on enable, write-1-to-clear by requester, the holding of a line by other pending interrupts, and the queuing of edges during a walk are shown by the bench's scenarios, with a per-clock reference model comparing lines, `busy` and read data.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int REG_W = 32;
  localparam int GROUP = 32;
  localparam logic [15:0] EN_BASE = 16'h0100;
  localparam logic [15:0] ST_BASE = 16'h0200;

  function automatic int safe_log2(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic bit in_region(logic [15:0] ofs, logic [15:0] base, int nwords);
    return (int'(ofs) >= int'(base)) && (int'(ofs) < int'(base) + nwords * 4);
  endfunction

  function automatic int word_index(logic [15:0] ofs, logic [15:0] base);
    return (int'(ofs) - int'(base)) >>> 2;
  endfunction

  function automatic int group_of(int irq);
    return irq / GROUP;
  endfunction
endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= lvl_in;
  end

  assign rise = lvl_in & ~raw_q;
  assign fall = ~lvl_in & raw_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign valid = |req;
endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import irq_router_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int N_CORE = 4,
  parameter int CORE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             reg_ofs,
  input  logic                    reg_wr,
  input  logic [REG_W-1:0]        reg_wdata,
  input  logic [CORE_W-1:0]       reg_req_id,
  input  logic [N_CORE*N_IRQ-1:0] status_flat,
  output logic [N_IRQ-1:0]        en_q,
  output logic [N_IRQ-1:0]        en_next,
  output logic [N_IRQ-1:0]        en_gain,
  output logic [N_IRQ-1:0]        en_lose,
  output logic                    clr_valid,
  output logic [CORE_W-1:0]       clr_core,
  output logic [N_IRQ-1:0]        clr_bits,
  output logic [REG_W-1:0]        reg_rdata
);
  localparam int N_WORD = N_IRQ / GROUP;

  logic en_hit, st_hit, id_ok;
  int   en_wi, st_wi;

  always_comb begin
    en_hit = in_region(reg_ofs, EN_BASE, N_WORD);
    st_hit = in_region(reg_ofs, ST_BASE, N_WORD);
    en_wi  = en_hit ? word_index(reg_ofs, EN_BASE) : 0;
    st_wi  = st_hit ? word_index(reg_ofs, ST_BASE) : 0;
    id_ok  = int'(reg_req_id) < N_CORE;
  end

  always_comb begin
    en_next = en_q;
    if (reg_wr && en_hit) en_next[en_wi*GROUP +: GROUP] = reg_wdata;
  end

  assign en_gain = en_next & ~en_q;
  assign en_lose = en_q & ~en_next;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_next;
  end

  always_comb begin
    clr_bits  = '0;
    clr_valid = reg_wr && st_hit && id_ok;
    clr_core  = reg_req_id;
    if (clr_valid)
      clr_bits[st_wi*GROUP +: GROUP] =
        status_flat[int'(reg_req_id)*N_IRQ + st_wi*GROUP +: GROUP] & reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (en_hit)
      reg_rdata = en_q[en_wi*GROUP +: GROUP];
    else if (st_hit && id_ok)
      reg_rdata = status_flat[int'(reg_req_id)*N_IRQ + st_wi*GROUP +: GROUP];
  end
endmodule

// File: rtl/irq_core_state.sv
module irq_core_state #(
  parameter int N_IRQ  = 64,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int CORE_W = 2,
  parameter int LINE_W = 2,
  parameter int IDX_W  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_valid,
  input  logic [CORE_W-1:0]              clr_core,
  input  logic [N_IRQ-1:0]               clr_bits,
  input  logic                           svc_valid,
  input  logic [IDX_W-1:0]               svc_idx,
  input  logic                           svc_up,
  input  logic [CORE_W-1:0]              svc_core,
  input  logic [LINE_W-1:0]              svc_line,
  output logic [N_CORE*N_IRQ-1:0]        status_q,
  output logic [N_CORE*N_LINE-1:0]       lines
);
  logic [N_CORE*N_LINE*N_IRQ-1:0] pset_q;
  logic [N_CORE*N_IRQ-1:0]        clr_full;
  logic                           svc_ok;

  always_comb begin
    clr_full = '0;
    if (clr_valid && int'(clr_core) < N_CORE)
      clr_full[int'(clr_core)*N_IRQ +: N_IRQ] = clr_bits;
    svc_ok = svc_valid && int'(svc_core) < N_CORE && int'(svc_line) < N_LINE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      pset_q   <= '0;
    end else begin
      status_q <= status_q & ~clr_full;
      if (svc_ok) begin
        status_q[int'(svc_core)*N_IRQ + int'(svc_idx)] <= svc_up;
        pset_q[(int'(svc_core)*N_LINE + int'(svc_line))*N_IRQ + int'(svc_idx)] <= svc_up;
      end
    end
  end

  for (genvar k = 0; k < N_CORE*N_LINE; k++) begin : g_line
    assign lines[k] = |pset_q[k*N_IRQ +: N_IRQ];
  end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_router_pkg::*;
#(
  parameter int N_IRQ  = 64,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  localparam int N_WORD = N_IRQ / 32,
  localparam int CORE_W = safe_log2(N_CORE),
  localparam int LINE_W = safe_log2(N_LINE),
  localparam int IDX_W  = safe_log2(N_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_IRQ-1:0]           irq_in,
  input  logic [N_IRQ*CORE_W-1:0]    route_core,
  input  logic [N_WORD*LINE_W-1:0]   route_line,
  input  logic [15:0]                reg_ofs,
  input  logic                       reg_wr,
  input  logic [31:0]                reg_wdata,
  input  logic [CORE_W-1:0]          reg_req_id,
  output logic [31:0]                reg_rdata,
  output logic [N_CORE*N_LINE-1:0]   line_out,
  output logic                       busy
);
  logic [N_IRQ-1:0] raw_q, rise_ev, fall_ev;
  logic [N_IRQ-1:0] en_q, en_next, en_gain, en_lose, clr_bits;
  logic [N_IRQ-1:0] up_q, dn_q, up_n, dn_n, req_any, served, rise_on;
  logic [N_CORE*N_IRQ-1:0] status_flat;
  logic              clr_valid;
  logic [CORE_W-1:0] clr_core;
  logic              svc_valid, svc_up;
  logic [IDX_W-1:0]  svc_idx;
  logic [CORE_W-1:0] svc_core;
  logic [LINE_W-1:0] svc_line;

  irq_edge_track #(.N(N_IRQ)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in(irq_in),
    .raw_q(raw_q), .rise(rise_ev), .fall(fall_ev)
  );

  irq_regport #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .CORE_W(CORE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_ofs(reg_ofs), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_req_id(reg_req_id), .status_flat(status_flat),
    .en_q(en_q), .en_next(en_next), .en_gain(en_gain), .en_lose(en_lose),
    .clr_valid(clr_valid), .clr_core(clr_core), .clr_bits(clr_bits),
    .reg_rdata(reg_rdata)
  );

  assign req_any = up_q | dn_q;

  irq_pick #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick (
    .req(req_any), .valid(svc_valid), .idx(svc_idx)
  );

  always_comb begin
    svc_up   = up_q[svc_idx];
    svc_core = route_core[int'(svc_idx)*CORE_W +: CORE_W];
    svc_line = route_line[group_of(int'(svc_idx))*LINE_W +: LINE_W];
    served   = '0;
    if (svc_valid) served[svc_idx] = 1'b1;
  end

  assign rise_on = rise_ev & en_next;

  always_comb begin
    up_n = up_q & ~served;
    dn_n = dn_q & ~served;
    up_n = (up_n | (en_gain & raw_q)) & ~(en_lose & raw_q) & ~clr_bits;
    dn_n = (dn_n | (en_lose & raw_q) | clr_bits) & ~(en_gain & raw_q);
    up_n = (up_n | rise_on) & ~fall_ev;
    dn_n = (dn_n | fall_ev) & ~rise_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  irq_core_state #(
    .N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_LINE(N_LINE),
    .CORE_W(CORE_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .clr_valid(clr_valid), .clr_core(clr_core),
    .clr_bits(clr_bits), .svc_valid(svc_valid), .svc_idx(svc_idx),
    .svc_up(svc_up), .svc_core(svc_core), .svc_line(svc_line),
    .status_q(status_flat), .lines(line_out)
  );

  assign busy = |req_any;
endmodule

// File: rtl/irq_steer_checker.sv
module irq_steer_checker #(
  parameter int N_IRQ  = 64,
  parameter int N_OUT  = 16,
  parameter int IDX_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [N_OUT-1:0] line_out,
  input logic             svc_valid,
  input logic             svc_up,
  input logic [IDX_W-1:0] svc_idx,
  input logic [N_IRQ-1:0] req_any,
  input logic [N_IRQ-1:0] rise_ev,
  input logic [N_IRQ-1:0] fall_ev,
  input logic [N_IRQ-1:0] en_next,
  input logic [N_IRQ-1:0] up_n,
  input logic [N_IRQ-1:0] dn_n
);
  logic [N_IRQ-1:0] below;
  always_comb begin
    below = '0;
    for (int i = 0; i < N_IRQ; i++) below[i] = req_any[i] && (i < int'(svc_idx));
  end

  AST_SVC_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> req_any[svc_idx]); // R11
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (below == '0)); // R8
  AST_IDLE_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !svc_valid); // R11
  AST_FALL_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev & ~dn_n) == '0); // R7
  AST_DISABLED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev & ~en_next & up_n) == '0); // R4

  for (genvar k = 0; k < N_OUT; k++) begin : g_ln
    AST_LINE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_out[k]) |-> $past(svc_valid && svc_up)); // R5
    AST_LINE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_out[k]) |-> $past(svc_valid && !svc_up)); // R6
  end
endmodule

bind irq_steer_router irq_steer_checker #(
  .N_IRQ(N_IRQ), .N_OUT(N_CORE*N_LINE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .line_out(line_out),
  .svc_valid(svc_valid), .svc_up(svc_up), .svc_idx(svc_idx),
  .req_any(req_any), .rise_ev(rise_ev), .fall_ev(fall_ev),
  .en_next(en_next), .up_n(up_n), .dn_n(dn_n)
);

// File: tb/sim_irq_steer_router.sv
module sim_irq_steer_router;
  localparam int N = 64;
  localparam int C = 4;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    irq_in = '0;
  logic [N*2-1:0]  route_core = '0;
  logic [3:0]      route_line = '0;
  logic [15:0]     reg_ofs = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [1:0]      reg_req_id = '0;
  logic [31:0]     reg_rdata;
  logic [C*L-1:0]  line_out;
  logic            busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irq_steer_router u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .route_core(route_core),
    .route_line(route_line), .reg_ofs(reg_ofs), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_req_id(reg_req_id), .reg_rdata(reg_rdata),
    .line_out(line_out), .busy(busy)
  );

  // behavioural reference
  bit [N-1:0] m_raw, m_en, m_up, m_dn;
  bit [N-1:0] m_st [C];
  bit [N-1:0] m_ps [C][L];

  function automatic int rc(int i); return int'(route_core[i*2 +: 2]); endfunction
  function automatic int rl(int i); return int'(route_line[(i/32)*2 +: 2]); endfunction

  function automatic bit [31:0] m_read(int ofs, int id);
    if (ofs >= 'h100 && ofs < 'h108) return m_en[((ofs-'h100)/4)*32 +: 32];
    if (ofs >= 'h200 && ofs < 'h208) return m_st[id][((ofs-'h200)/4)*32 +: 32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = '0; m_en = '0; m_up = '0; m_dn = '0;
      for (int c = 0; c < C; c++) begin
        m_st[c] = '0;
        for (int l = 0; l < L; l++) m_ps[c][l] = '0;
      end
    end else begin
      int sv;
      int ofs;
      bit [N-1:0] en_new, cm;
      sv = -1;
      for (int i = 0; i < N; i++) if (sv < 0 && (m_up[i] || m_dn[i])) sv = i;
      ofs = int'(reg_ofs);
      en_new = m_en;
      cm = '0;
      if (reg_wr && ofs >= 'h100 && ofs < 'h108) en_new[((ofs-'h100)/4)*32 +: 32] = reg_wdata;
      if (reg_wr && ofs >= 'h200 && ofs < 'h208)
        for (int b = 0; b < 32; b++) begin
          int i2;
          i2 = ((ofs-'h200)/4)*32 + b;
          cm[i2] = m_st[reg_req_id][i2] && reg_wdata[b];
        end
      m_st[reg_req_id] = m_st[reg_req_id] & ~cm;
      if (sv >= 0) begin
        m_st[rc(sv)][sv] = m_up[sv];
        m_ps[rc(sv)][rl(sv)][sv] = m_up[sv];
        m_up[sv] = 0; m_dn[sv] = 0;
      end
      for (int i = 0; i < N; i++) begin
        if (en_new[i] && !m_en[i] && m_raw[i]) begin m_up[i] = 1; m_dn[i] = 0; end
        if (!en_new[i] && m_en[i] && m_raw[i]) begin m_dn[i] = 1; m_up[i] = 0; end
        if (cm[i]) begin m_dn[i] = 1; m_up[i] = 0; end
        if (irq_in[i] && !m_raw[i] && en_new[i]) begin m_up[i] = 1; m_dn[i] = 0; end
        if (!irq_in[i] && m_raw[i]) begin m_dn[i] = 1; m_up[i] = 0; end
      end
      m_raw = irq_in;
      m_en = en_new;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      bit [C*L-1:0] el;
      bit [31:0] er;
      for (int c = 0; c < C; c++)
        for (int l = 0; l < L; l++) el[c*L+l] = |m_ps[c][l];
      checks++;
      if (line_out !== el) begin
        fails++;
        $display("FAIL R6 line_out act=%h exp=%h at %0t", line_out, el, $time);
      end
      checks++;
      if (busy !== (|(m_up | m_dn))) begin
        fails++;
        $display("FAIL R11 busy act=%b exp=%b at %0t", busy, |(m_up | m_dn), $time);
      end
      er = m_read(int'(reg_ofs), int'(reg_req_id));
      checks++;
      if (reg_rdata !== er) begin
        fails++;
        $display("FAIL R3 rdata act=%h exp=%h at %0t", reg_rdata, er, $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [15:0] ofs, logic [1:0] id, output logic [31:0] d);
    reg_ofs = ofs; reg_req_id = id; reg_wr = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wr(logic [15:0] ofs, logic [1:0] id, logic [31:0] d);
    reg_ofs = ofs; reg_req_id = id; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_ofs = 16'h0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 lines", 32'(line_out), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    rd(16'h0100, 2'd0, d); chk("R1 enable word", d, 32'h0);
    rd(16'h0204, 2'd3, d); chk("R1 status word", d, 32'h0);

    // routing: irq3,5 -> core1, irq40,41 -> core2; group0 -> line2, group1 -> line3
    route_core[3*2 +: 2] = 2'd1;
    route_core[5*2 +: 2] = 2'd1;
    route_core[40*2 +: 2] = 2'd2;
    route_core[41*2 +: 2] = 2'd2;
    route_line = {2'd3, 2'd2};
    cyc(1);

    // R4 disabled rise does nothing
    irq_in[5] = 1'b1;
    cyc(4);
    chk("R4 lines", 32'(line_out), 32'h0);
    rd(16'h0200, 2'd1, d); chk("R4 status", d, 32'h0);

    // R3 / R8 replay on enable
    wr(16'h0100, 2'd0, 32'h0000_0028);
    rd(16'h0100, 2'd0, d); chk("R3 readback", d, 32'h0000_0028);
    cyc(2);
    rd(16'h0200, 2'd1, d); chk("R8 replay status", d, 32'h0000_0020);
    chk("R8 replay line", 32'(line_out), 32'h0040);

    // R5 enabled rise
    irq_in[3] = 1'b1;
    cyc(1);
    chk("R5 not yet", 32'(line_out), 32'h0040);
    cyc(2);
    rd(16'h0200, 2'd1, d); chk("R5 status", d, 32'h0000_0028);

    // R6 hold by other pending irq
    irq_in[5] = 1'b0;
    cyc(3);
    rd(16'h0200, 2'd1, d); chk("R7 fall clears", d, 32'h0000_0008);
    chk("R6 line held", 32'(line_out), 32'h0040);

    // R10 wrong requester leaves core1 alone
    wr(16'h0200, 2'd0, 32'hFFFF_FFFF);
    rd(16'h0200, 2'd1, d); chk("R10 other core", d, 32'h0000_0008);
    // R9 write-1-to-clear by core1
    wr(16'h0200, 2'd1, 32'h0000_0008);
    rd(16'h0200, 2'd1, d); chk("R9 cleared", d, 32'h0);
    cyc(2);
    chk("R9 line drop", 32'(line_out), 32'h0);

    // R2 unmapped offset
    wr(16'h0300, 2'd0, 32'hFFFF_FFFF);
    rd(16'h0300, 2'd0, d); chk("R2 unmapped", d, 32'h0);
    rd(16'h0100, 2'd0, d); chk("R2 enable unchanged", d, 32'h0000_0028);

    // R8 / R11 ordered walk
    irq_in[40] = 1'b1; irq_in[41] = 1'b1;
    cyc(3);
    wr(16'h0104, 2'd0, 32'h0000_0300);
    chk("R11 busy walk", 32'(busy), 32'h1);
    chk("R8 none served", 32'(line_out), 32'h0);
    irq_in[41] = 1'b0;
    cyc(1);
    rd(16'h0204, 2'd2, d); chk("R8 lowest first", d, 32'h0000_0100);
    chk("R5 line11", 32'(line_out), 32'h0800);
    cyc(2);
    chk("R11 idle", 32'(busy), 32'h0);
    rd(16'h0204, 2'd2, d); chk("R11 queued fall", d, 32'h0000_0100);

    // R7 fall while disabled after disable lowers
    wr(16'h0104, 2'd0, 32'h0);
    cyc(2);
    chk("R8 disable lowers", 32'(line_out), 32'h0);
    irq_in[40] = 1'b0;
    cyc(3);
    rd(16'h0204, 2'd2, d); chk("R7 disabled fall", d, 32'h0);
    chk("R7 idle", 32'(busy), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule